// File: doc/BRIEF.md
# Linked-List Command Chain Walker

This block follows a chain of command packets held in a word-addressed memory and forwards each packet's payload words, in order, to a graphics command port. Every packet starts with one header word. The upper byte of the header gives how many payload words follow it. The lower 24 bits point at the next packet. Software loads a start pointer and then writes the channel control register with the chain-mode code. The walker then runs on its own until the list ends.

A walk ends in one of three ways. The first is a next pointer whose bit 23 is set. The second is a revisit of an address held in a small three-entry history. The third is a packet count beyond a fixed limit. When the walk ends, the pointer register holds the value that stopped it, the busy bit of the control register drops and a one-cycle interrupt pulse follows. Memory is modelled as a read port with a fixed one-cycle latency. Payload words appear on the command port one cycle after each read.

Top module: `gfx_chain_walker`

## Requirements
- R1: Writing the control register with 0x01000401 while idle starts a walk. In the next cycle, bit 24 (busy) of the control output reads 1 and a header read is issued at the masked start pointer.
- R2: In a header, bits [31:24] are the payload word count and bits [23:0] are the next pointer. Payload words are read in ascending order from header address + 4 and appear on the command port one per cycle, in that order. A count of zero sends nothing.
- R3: Every packet and payload address is the pointer ANDed with 0x1FFFFC, which gives a word-aligned byte address in a 2 MB space.
- R4: A next pointer with bit 23 set ends the walk, whatever its other bits are. The pointer output then holds that full 24-bit value.
- R5: If a packet address equals the stored low entry or the stored high entry of the history, the walk stops before that header is read. The pointer output then holds that address.
- R6: All three history entries (last, low, high) are set to 0xFFFFFF at the start of each walk. After each accepted packet, its address goes into low if it is below last, and into high otherwise. It then becomes last.
- R7: At most STEP_LIMIT+1 headers are read in one walk. The check that follows ends the walk, and the pointer output holds the address that would have been read next.
- R8: At the end of a walk, bit 24 of the control output clears and its other bits are kept. The interrupt output is high for exactly the first cycle in which busy reads 0. The end comes one cycle after the last packet's final payload read, or one cycle after the header read that ends the list, or at the failed check.
- R9: Writes to the control register or to the pointer register while busy are ignored. This includes a write in the cycle in which the walk ends.
- R10: A control write of any value other than the chain code while idle is stored with bit 24 cleared. It starts no memory reads and raises no interrupt.
- R11: After reset, the control output and the pointer output are zero, and the interrupt, memory read and command-port valid outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 32 | Control register write value |
| madr_wr_i | input | 1 | Pointer register write strobe |
| madr_wdata_i | input | 24 | Pointer register write value |
| chan_ctl_o | output | 32 | Control register; bit 24 is busy |
| list_ptr_o | output | 24 | Pointer register (start, then terminating value) |
| irq_o | output | 1 | One-cycle end-of-walk pulse |
| mem_rd_o | output | 1 | Memory read request |
| mem_addr_o | output | 21 | Memory byte address, word aligned |
| mem_rdata_i | input | 32 | Memory read data, valid one cycle after the request |
| gp_valid_o | output | 1 | Command-port word valid |
| gp_data_o | output | 32 | Command-port payload word |

## Verification
End-of-walk and a register write can fall in the same cycle. The bench's reference model predicts the exact cycle in which the walk ends. In that cycle the bench drives a chain-code control write and a pointer write together. It then expects no restart, the terminating pointer unchanged, and the interrupt one cycle later. Loop detection and the step limit can also fire on the same check. The bench runs a revisiting chain whose history has been overwritten, so only the limit stops it, and compares the resulting pointer with a hand-derived address.

// File: rtl/gcw_pkg.sv
package gcw_pkg;

   typedef enum logic [2:0] {
      WS_IDLE,
      WS_CHECK,
      WS_HDR,
      WS_PAY,
      WS_ADV
   } walk_state_e;

endpackage

// File: rtl/gcw_loop_guard.sv
module gcw_loop_guard #(
   parameter int ADDR_W = 21,
   parameter int PTR_W  = 24,
   parameter bit ENABLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              step,
   input  logic [ADDR_W-1:0] cur_addr,
   output logic              hit
);

   if (ADDR_W >= PTR_W) begin : g_bad_width
      $error("gcw_loop_guard: ADDR_W must be below PTR_W");
   end

   if (ENABLE) begin : g_guard
      localparam logic [PTR_W-1:0] EMPTY = '1;
      logic [PTR_W-1:0] last_q;
      logic [PTR_W-1:0] low_q;
      logic [PTR_W-1:0] high_q;
      logic [PTR_W-1:0] cur_ext;

      assign cur_ext = PTR_W'(cur_addr);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            last_q <= EMPTY;
            low_q  <= EMPTY;
            high_q <= EMPTY;
         end else if (clear) begin
            last_q <= EMPTY;
            low_q  <= EMPTY;
            high_q <= EMPTY;
         end else if (step) begin
            if (cur_ext < last_q) low_q <= cur_ext;
            else                  high_q <= cur_ext;
            last_q <= cur_ext;
         end
      end

      assign hit = (cur_ext == low_q) || (cur_ext == high_q);

      // R6
      guard_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
         clear |=> !hit);

      // R5
      repeat_detect_chk: assert property (@(posedge clk) disable iff (!rst_n)
         step |=> ((cur_addr != $past(cur_addr)) || hit));
   end else begin : g_bypass
      logic unused_guard_in;
      assign unused_guard_in = ^{clear, step, cur_addr};
      assign hit = 1'b0;
   end

endmodule

// File: rtl/gcw_step_limit.sv
module gcw_step_limit #(
   parameter int LIMIT = 2000000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic step,
   output logic over
);

   localparam int            CW  = $clog2(LIMIT + 2);
   localparam logic [CW-1:0] CAP = CW'(LIMIT + 1);

   if (LIMIT < 1) begin : g_bad_limit
      $error("gcw_step_limit: LIMIT must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt_q <= '0;
      else if (clear)                cnt_q <= '0;
      else if (step && cnt_q != CAP) cnt_q <= cnt_q + CW'(1);
   end

   assign over = (cnt_q == CAP);

   // R7
   cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CAP);

   // R7
   no_step_past_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      over |-> !step);

endmodule

// File: rtl/gcw_sequencer.sv
module gcw_sequencer
   import gcw_pkg::*;
#(
   parameter int ADDR_W = 21,
   parameter int DATA_W = 32,
   parameter int PTR_W  = 24,
   parameter int LEN_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [PTR_W-1:0]  start_ptr,
   input  logic              loop_hit,
   input  logic              step_over,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              mem_rd,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              gp_valid,
   output logic [DATA_W-1:0] gp_data,
   output logic              hist_clear,
   output logic              hist_step,
   output logic [ADDR_W-1:0] walk_addr,
   output logic              done,
   output logic [PTR_W-1:0]  done_ptr
);

   localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(4);
   localparam logic [LEN_W-1:0]  LEN_ONE   = LEN_W'(1);

   if (DATA_W != PTR_W + LEN_W) begin : g_bad_header
      $error("gcw_sequencer: DATA_W must equal PTR_W + LEN_W");
   end

   function automatic logic [ADDR_W-1:0] align_ptr(input logic [PTR_W-1:0] p);
      return {p[ADDR_W-1:2], 2'b00};
   endfunction

   walk_state_e       state_q;
   logic [ADDR_W-1:0] cur_q;
   logic [ADDR_W-1:0] paddr_q;
   logic [LEN_W-1:0]  remain_q;
   logic [PTR_W-1:0]  next_q;
   logic              pay_q;
   logic              abort;
   logic [LEN_W-1:0]  hdr_len;
   logic [PTR_W-1:0]  hdr_next;
   logic              unused_ptr_hi;

   assign hdr_len       = mem_rdata[DATA_W-1 -: LEN_W];
   assign hdr_next      = mem_rdata[PTR_W-1:0];
   assign unused_ptr_hi = ^start_ptr[PTR_W-1:ADDR_W];

   assign abort      = (state_q == WS_CHECK) && (loop_hit || step_over);
   assign hist_clear = start && (state_q == WS_IDLE);
   assign walk_addr  = cur_q;
   assign gp_valid   = pay_q;
   assign gp_data    = mem_rdata;

   always_comb begin
      mem_rd    = 1'b0;
      mem_addr  = cur_q;
      hist_step = 1'b0;
      unique case (state_q)
         WS_CHECK: begin
            if (!abort) begin
               mem_rd    = 1'b1;
               hist_step = 1'b1;
            end
         end
         WS_PAY: begin
            mem_rd   = 1'b1;
            mem_addr = paddr_q;
         end
         default: ;
      endcase
   end

   assign done     = abort || ((state_q == WS_ADV) && next_q[PTR_W-1]);
   assign done_ptr = (state_q == WS_ADV) ? next_q : PTR_W'(cur_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= WS_IDLE;
         cur_q    <= '0;
         paddr_q  <= '0;
         remain_q <= '0;
         next_q   <= '0;
         pay_q    <= 1'b0;
      end else begin
         pay_q <= (state_q == WS_PAY);
         unique case (state_q)
            WS_IDLE: begin
               if (start) begin
                  cur_q   <= align_ptr(start_ptr);
                  state_q <= WS_CHECK;
               end
            end
            WS_CHECK: begin
               state_q <= abort ? WS_IDLE : WS_HDR;
            end
            WS_HDR: begin
               remain_q <= hdr_len;
               next_q   <= hdr_next;
               paddr_q  <= cur_q + WORD_STEP;
               state_q  <= (hdr_len == '0) ? WS_ADV : WS_PAY;
            end
            WS_PAY: begin
               paddr_q  <= paddr_q + WORD_STEP;
               remain_q <= remain_q - LEN_ONE;
               if (remain_q == LEN_ONE) state_q <= WS_ADV;
            end
            WS_ADV: begin
               if (next_q[PTR_W-1]) begin
                  state_q <= WS_IDLE;
               end else begin
                  cur_q   <= align_ptr(next_q);
                  state_q <= WS_CHECK;
               end
            end
            default: state_q <= WS_IDLE;
         endcase
      end
   end

   // R2
   gp_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gp_valid |-> $past(mem_rd));

   // R1
   start_reads_header_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hist_clear |=> (mem_rd || done));

endmodule

// File: rtl/gfx_chain_walker.sv
module gfx_chain_walker #(
   parameter int                ADDR_W     = 21,
   parameter int                LEN_W      = 8,
   parameter int                PTR_W      = 24,
   parameter int                DATA_W     = 32,
   parameter int                STEP_LIMIT = 2000000,
   parameter int                BUSY_BIT   = 24,
   parameter logic [DATA_W-1:0] CHAIN_CODE = 32'h0100_0401,
   parameter bit                LOOP_GUARD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr_i,
   input  logic [DATA_W-1:0] ctl_wdata_i,
   input  logic              madr_wr_i,
   input  logic [PTR_W-1:0]  madr_wdata_i,
   output logic [DATA_W-1:0] chan_ctl_o,
   output logic [PTR_W-1:0]  list_ptr_o,
   output logic              irq_o,
   output logic              mem_rd_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   input  logic [DATA_W-1:0] mem_rdata_i,
   output logic              gp_valid_o,
   output logic [DATA_W-1:0] gp_data_o
);

   localparam logic [DATA_W-1:0] BUSY_MASK = DATA_W'(1) << BUSY_BIT;

   if (BUSY_BIT >= DATA_W) begin : g_bad_busy
      $error("gfx_chain_walker: BUSY_BIT out of range");
   end
   if (CHAIN_CODE[BUSY_BIT] != 1'b1) begin : g_bad_code
      $error("gfx_chain_walker: CHAIN_CODE must set the busy bit");
   end

   logic [DATA_W-1:0] ctl_q;
   logic [PTR_W-1:0]  ptr_q;
   logic              irq_q;
   logic              busy;
   logic              start;
   logic              loop_hit;
   logic              step_over;
   logic              hist_clear;
   logic              hist_step;
   logic [ADDR_W-1:0] walk_addr;
   logic              walk_done;
   logic [PTR_W-1:0]  done_ptr;

   assign busy  = ctl_q[BUSY_BIT];
   assign start = ctl_wr_i && !busy && (ctl_wdata_i == CHAIN_CODE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
         ptr_q <= '0;
         irq_q <= 1'b0;
      end else begin
         irq_q <= walk_done;
         if (walk_done) begin
            ctl_q[BUSY_BIT] <= 1'b0;
            ptr_q           <= done_ptr;
         end else if (!busy) begin
            if (ctl_wr_i)
               ctl_q <= (ctl_wdata_i == CHAIN_CODE) ? ctl_wdata_i
                                                    : (ctl_wdata_i & ~BUSY_MASK);
            if (madr_wr_i)
               ptr_q <= madr_wdata_i;
         end
      end
   end

   gcw_sequencer #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PTR_W(PTR_W), .LEN_W(LEN_W)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .start_ptr  (ptr_q),
      .loop_hit   (loop_hit),
      .step_over  (step_over),
      .mem_rdata  (mem_rdata_i),
      .mem_rd     (mem_rd_o),
      .mem_addr   (mem_addr_o),
      .gp_valid   (gp_valid_o),
      .gp_data    (gp_data_o),
      .hist_clear (hist_clear),
      .hist_step  (hist_step),
      .walk_addr  (walk_addr),
      .done       (walk_done),
      .done_ptr   (done_ptr)
   );

   gcw_loop_guard #(
      .ADDR_W(ADDR_W), .PTR_W(PTR_W), .ENABLE(LOOP_GUARD)
   ) u_guard (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (hist_clear),
      .step     (hist_step),
      .cur_addr (walk_addr),
      .hit      (loop_hit)
   );

   gcw_step_limit #(
      .LIMIT(STEP_LIMIT)
   ) u_limit (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (hist_clear),
      .step  (hist_step),
      .over  (step_over)
   );

   assign chan_ctl_o = ctl_q;
   assign list_ptr_o = ptr_q;
   assign irq_o      = irq_q;

   // R8
   irq_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> $fell(chan_ctl_o[BUSY_BIT]));

   // R8
   fall_gives_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(chan_ctl_o[BUSY_BIT]) |-> irq_o);

   // R10
   read_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_o |-> busy);

   // R9
   locked_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !walk_done && (ctl_wr_i || madr_wr_i)) |=> ($stable(chan_ctl_o) && $stable(list_ptr_o)));

endmodule

// File: tb/gfx_chain_walker_bench.sv
`timescale 1ns/100ps
module gfx_chain_walker_bench;

   localparam int          LIM   = 5;
   localparam logic [31:0] CODE  = 32'h0100_0401;
   localparam int          WDOG  = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_wr = 1'b0;
   logic [31:0] ctl_wdata = '0;
   logic        madr_wr = 1'b0;
   logic [23:0] madr_wdata = '0;
   logic [31:0] chan_ctl;
   logic [23:0] list_ptr;
   logic        irq;
   logic        mem_rd;
   logic [20:0] mem_addr;
   logic [31:0] mem_rdata = '0;
   logic        gp_valid;
   logic [31:0] gp_data;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   logic [31:0] mem [0:1023];
   logic [31:0] exp_q [$];

   always #2.5 clk = ~clk;

   gfx_chain_walker #(.STEP_LIMIT(LIM)) u_gfx_chain_walker (
      .clk(clk), .rst_n(rst_n), .ctl_wr_i(ctl_wr), .ctl_wdata_i(ctl_wdata),
      .madr_wr_i(madr_wr), .madr_wdata_i(madr_wdata), .chan_ctl_o(chan_ctl),
      .list_ptr_o(list_ptr), .irq_o(irq), .mem_rd_o(mem_rd), .mem_addr_o(mem_addr),
      .mem_rdata_i(mem_rdata), .gp_valid_o(gp_valid), .gp_data_o(gp_data)
   );

   always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[11:2]];

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // reference comparison of the command port on every clock (R2)
   always @(negedge clk) begin
      cyc++;
      if (rst_n && gp_valid) begin
         if (exp_q.size() == 0) chk(1'b0, "R2 unexpected payload word", gp_data, 32'h0);
         else begin
            logic [31:0] e;
            e = exp_q.pop_front();
            chk(gp_data == e, "R2 payload order", gp_data, e);
         end
      end
      if (cyc == WDOG) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%0d expected<%0d", cyc, WDOG);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   function automatic logic [31:0] hdr(input int n, input logic [23:0] nxt);
      return {8'(n), nxt};
   endfunction

   task automatic run_walk(input logic [23:0] sp, input bit poke, input string tag,
                           output logic [23:0] got_ptr);
      logic [23:0] cur, last, lo, hi, nxt, em;
      logic [31:0] h;
      int steps, d, n, cycle;
      bit bad;
      cur = sp & 24'h1FFFFC;
      last = 24'hFFFFFF; lo = 24'hFFFFFF; hi = 24'hFFFFFF;
      steps = 0; d = 0; em = '0;
      forever begin
         if (steps > LIM || cur == lo || cur == hi) begin em = cur; d += 1; break; end
         if (cur < last) lo = cur; else hi = cur;
         last = cur; steps++;
         h = mem[cur[11:2]];
         n = int'(h[31:24]);
         for (int i = 1; i <= n; i++) begin
            logic [23:0] a;
            a = (cur + 24'(4 * i)) & 24'h1FFFFC;
            exp_q.push_back(mem[a[11:2]]);
         end
         d += 3 + n;
         nxt = h[23:0];
         if (nxt[23]) begin em = nxt; break; end
         cur = nxt & 24'h1FFFFC;
      end
      @(negedge clk); madr_wr = 1'b1; madr_wdata = sp;
      @(negedge clk); madr_wr = 1'b0; ctl_wr = 1'b1; ctl_wdata = CODE;
      @(negedge clk); ctl_wr = 1'b0;
      chk(chan_ctl[24] == 1'b1, "R1 busy after start", 32'(chan_ctl[24]), 32'h1);
      chk(mem_rd && (mem_addr == (sp[20:0] & 21'h1FFFFC)), "R1/R3 first header address",
          32'(mem_addr), 32'(sp[20:0] & 21'h1FFFFC));
      cycle = 1; bad = 1'b0;
      while (cycle < d) begin
         if (!chan_ctl[24] || irq) bad = 1'b1;
         @(negedge clk); cycle++;
      end
      if (!chan_ctl[24] || irq) bad = 1'b1;
      chk(!bad, "R8 busy held until end", 32'(bad), 32'h0);
      if (poke) begin
         ctl_wr = 1'b1; ctl_wdata = CODE; madr_wr = 1'b1; madr_wdata = 24'h000123;
      end
      @(negedge clk);
      ctl_wr = 1'b0; madr_wr = 1'b0;
      chk(irq == 1'b1, "R8 irq in first idle cycle", 32'(irq), 32'h1);
      chk(chan_ctl == 32'h0000_0401, "R8 busy cleared, other bits kept", chan_ctl, 32'h0000_0401);
      chk(list_ptr == em, tag, 32'(list_ptr), 32'(em));
      chk(exp_q.size() == 0, "R2 all payload delivered", 32'(exp_q.size()), 32'h0);
      got_ptr = list_ptr;
      @(negedge clk);
      chk(irq == 1'b0, "R8 irq is one cycle", 32'(irq), 32'h0);
      if (poke) chk(!mem_rd && !chan_ctl[24] && list_ptr == em,
                    "R9 write in end cycle ignored", chan_ctl, 32'h0000_0401);
   endtask

   initial begin
      logic [23:0] p;
      bit quiet;
      for (int i = 0; i < 1024; i++) mem[i] = 32'hA000_0000 | 32'(i);
      // chain with end marker 0xFFFFFF and a masked pointer
      mem[32'h100 >> 2] = hdr(2, 24'h000200);
      mem[32'h200 >> 2] = hdr(0, 24'h600400);
      mem[32'h400 >> 2] = hdr(3, 24'hFFFFFF);
      // odd terminator
      mem[32'h140 >> 2] = hdr(1, 24'h812345);
      // two-packet loop
      mem[32'h300 >> 2] = hdr(1, 24'h000380);
      mem[32'h380 >> 2] = hdr(1, 24'h000300);
      // self loop
      mem[32'h500 >> 2] = hdr(0, 24'h000500);
      // revisiting chain that escapes the history
      mem[32'h700 >> 2] = hdr(0, 24'h000680);
      mem[32'h680 >> 2] = hdr(0, 24'h000740);
      mem[32'h740 >> 2] = hdr(0, 24'h0006C0);
      mem[32'h6C0 >> 2] = hdr(0, 24'h000700);
      // long ascending chain
      for (int k = 0; k < 10; k++)
         mem[(32'h800 + 32'(k) * 32'h40) >> 2] = hdr(1, 24'h000800 + 24'(k + 1) * 24'h40);

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(chan_ctl == 32'h0, "R11 control after reset", chan_ctl, 32'h0);
      chk(list_ptr == 24'h0, "R11 pointer after reset", 32'(list_ptr), 32'h0);
      chk(!irq && !mem_rd && !gp_valid, "R11 strobes low after reset",
          {29'h0, irq, mem_rd, gp_valid}, 32'h0);

      // R10: non-chain code
      ctl_wr = 1'b1; ctl_wdata = 32'h0100_0200;
      @(negedge clk); ctl_wr = 1'b0;
      chk(chan_ctl == 32'h0000_0200, "R10 other code stored without busy", chan_ctl, 32'h0000_0200);
      quiet = 1'b1;
      repeat (5) begin
         if (mem_rd || irq || gp_valid) quiet = 1'b0;
         @(negedge clk);
      end
      chk(quiet, "R10 no reads or irq", 32'(quiet), 32'h1);

      run_walk(24'h600103, 1'b0, "R4 all-ones terminator", p);
      chk(p == 24'hFFFFFF, "R4 pointer holds 0xFFFFFF", 32'(p), 32'h00FF_FFFF);

      run_walk(24'h000140, 1'b1, "R4 bit-23 terminator", p);
      chk(p == 24'h812345, "R4 pointer holds full terminator", 32'(p), 32'h0081_2345);

      run_walk(24'h000300, 1'b0, "R5 two-packet loop", p);
      chk(p == 24'h000300, "R5 loop stops at repeat", 32'(p), 32'h0000_0300);

      run_walk(24'h000500, 1'b0, "R5 self loop", p);
      chk(p == 24'h000500, "R5 self loop address", 32'(p), 32'h0000_0500);
      run_walk(24'h000500, 1'b0, "R6 history reset on second walk", p);
      chk(p == 24'h000500, "R6 second walk pointer", 32'(p), 32'h0000_0500);

      run_walk(24'h000700, 1'b1, "R6 overwritten history", p);
      chk(p == 24'h000740, "R7 revisiting chain stopped by limit", 32'(p), 32'h0000_0740);

      run_walk(24'h000800, 1'b0, "R7 ascending chain", p);
      chk(p == 24'h000980, "R7 limit pointer", 32'(p), 32'h0000_0980);

      // R9: writes during a walk
      @(negedge clk); madr_wr = 1'b1; madr_wdata = 24'h000100;
      @(negedge clk); madr_wr = 1'b0; ctl_wr = 1'b1; ctl_wdata = CODE;
      mem[32'h100 >> 2] = hdr(2, 24'hFFFFFF);
      exp_q.push_back(mem[32'h104 >> 2]);
      exp_q.push_back(mem[32'h108 >> 2]);
      @(negedge clk); ctl_wr = 1'b1; ctl_wdata = 32'h0; madr_wr = 1'b1; madr_wdata = 24'h000777;
      @(negedge clk); ctl_wr = 1'b0; madr_wr = 1'b0;
      chk(chan_ctl == CODE && list_ptr == 24'h000100, "R9 writes while busy ignored",
          chan_ctl, CODE);
      repeat (8) @(negedge clk);
      chk(list_ptr == 24'hFFFFFF && !chan_ctl[24], "R9 walk finished normally",
          32'(list_ptr), 32'h00FF_FFFF);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule